// File: doc/BRIEF.md
# Classic/Pipelined Bus Mode Bridge

This block joins a Wishbone initiator to a Wishbone subordinate. Each side may use classic handshaking or pipelined handshaking. Two parameters fix the mode of each side. Address, write enable, byte selects, write data and cycle valid go straight through to the subordinate. Read data and the acknowledge come straight back. Both sides share one clock and one synchronous active-high reset, and both have the same widths.

When the two modes differ, the bridge supplies the handshake that is missing. For a pipelined initiator in front of a classic subordinate, the bridge produces a stall toward the initiator. That stall stays high until the subordinate acknowledges, so only one transfer is ever in flight. For a classic initiator in front of a pipelined subordinate, the bridge keeps a one-bit accepted flag. The flag masks the strobe once the subordinate has taken the request, so one classic cycle turns into exactly one pipelined request. When both sides use the same mode, the bridge is pure wiring.

Top module: `wb_mode_bridge`

## Requirements
- R1: In every mode, s_adr, s_we, s_sel, s_dat_w and s_cyc equal i_adr, i_we, i_sel, i_dat_w and i_cyc in the same cycle, and i_dat_r equals s_dat_r in the same cycle.
- R2: In every mode, i_ack equals s_ack in the same cycle, so it drops in the cycle in which the subordinate removes its acknowledge.
- R3: With both sides pipelined (INI_PIPE=1, SUB_PIPE=1), i_stall equals s_stall and s_stb equals i_stb, including the cycles in which the stall is high.
- R4: With a pipelined initiator and a classic subordinate (INI_PIPE=1, SUB_PIPE=0), s_stb equals i_stb. i_stall is 1 when i_cyc and i_stb are both 1 and s_ack is 0. Otherwise i_stall is 0, in particular in the cycle in which s_ack is 1.
- R5: With a classic initiator and a pipelined subordinate (INI_PIPE=0, SUB_PIPE=1), the accepted flag is set at a clock edge where i_cyc=1, i_stb=1, s_stall=0 and s_ack=0. While the flag is set, s_stb is 0. While the flag is clear, s_stb equals i_stb, so a stalled request stays presented.
- R6: In the same mode, the accepted flag clears at an edge where s_ack=1 or i_cyc=0. In the following cycle, s_stb again equals i_stb, which lets back-to-back requests go out.
- R7: With a classic initiator (INI_PIPE=0), i_stall is always 0. With both sides classic, s_stb equals i_stb.
- R8: A clock edge with rst=1 clears the accepted flag, so after reset s_stb equals i_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| i_cyc | input | 1 | Initiator cycle valid |
| i_stb | input | 1 | Initiator strobe |
| i_adr | input | AW | Initiator address |
| i_we | input | 1 | Initiator write enable |
| i_sel | input | SW | Initiator byte selects |
| i_dat_w | input | DW | Initiator write data |
| i_dat_r | output | DW | Read data returned to the initiator |
| i_ack | output | 1 | Acknowledge returned to the initiator |
| i_stall | output | 1 | Stall returned to the initiator |
| s_cyc | output | 1 | Subordinate cycle valid |
| s_stb | output | 1 | Subordinate strobe |
| s_adr | output | AW | Subordinate address |
| s_we | output | 1 | Subordinate write enable |
| s_sel | output | SW | Subordinate byte selects |
| s_dat_w | output | DW | Subordinate write data |
| s_dat_r | input | DW | Subordinate read data |
| s_ack | input | 1 | Subordinate acknowledge |
| s_stall | input | 1 | Subordinate stall (pipelined subordinate only) |

## Verification
The hardest case to reach is the classic-to-pipelined mode with the accepted flag set while the initiator strobe stays high. Covering it requires a stall of several cycles, then an acceptance, then a delayed acknowledge, and then a second request right behind it. Directed sequences build exactly that pattern: a multi-cycle stall, a late acknowledge, a cycle abort and a reset while the flag is set. Long random runs mix strobe, stall and acknowledge at independent rates on all four mode instances at once. A bench model of the flag predicts the strobe for every cycle.

// File: rtl/wb_mode_bridge.sv
module wb_mode_bridge #(
  parameter int AW       = 10,
  parameter int DW       = 32,
  parameter int SW       = DW / 8,
  parameter bit INI_PIPE = 1'b0,
  parameter bit SUB_PIPE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          i_cyc,
  input  logic          i_stb,
  input  logic [AW-1:0] i_adr,
  input  logic          i_we,
  input  logic [SW-1:0] i_sel,
  input  logic [DW-1:0] i_dat_w,
  output logic [DW-1:0] i_dat_r,
  output logic          i_ack,
  output logic          i_stall,
  output logic          s_cyc,
  output logic          s_stb,
  output logic [AW-1:0] s_adr,
  output logic          s_we,
  output logic [SW-1:0] s_sel,
  output logic [DW-1:0] s_dat_w,
  input  logic [DW-1:0] s_dat_r,
  input  logic          s_ack,
  input  logic          s_stall
);

  assign s_cyc   = i_cyc;
  assign s_adr   = i_adr;
  assign s_we    = i_we;
  assign s_sel   = i_sel;
  assign s_dat_w = i_dat_w;
  assign i_dat_r = s_dat_r;
  assign i_ack   = s_ack;

  if (INI_PIPE && SUB_PIPE) begin : g_pipe_pipe
    assign i_stall = s_stall;
    assign s_stb   = i_stb;

    AST_STALL_PASS: assert property (@(posedge clk) disable iff (rst)
      (i_stb && i_stall) |-> (s_stb && s_stall)); // R3

  end else if (INI_PIPE && !SUB_PIPE) begin : g_pipe_classic
    assign s_stb   = i_stb;
    assign i_stall = i_cyc & i_stb & ~s_ack;

    AST_ACCEPT_ON_ACK: assert property (@(posedge clk) disable iff (rst)
      (i_cyc && i_stb && !i_stall) |-> s_ack); // R4

  end else if (!INI_PIPE && SUB_PIPE) begin : g_classic_pipe
    logic accepted;

    always_ff @(posedge clk) begin
      if (rst)                  accepted <= 1'b0;
      else if (!i_cyc || s_ack) accepted <= 1'b0;
      else if (i_stb && !s_stall) accepted <= 1'b1;
    end

    assign s_stb   = i_stb & ~accepted;
    assign i_stall = 1'b0;

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
      (i_cyc && s_stb && !s_stall && !s_ack) |=> !s_stb); // R5
    AST_STALL_KEEP: assert property (@(posedge clk) disable iff (rst)
      (i_cyc && s_stb && s_stall) |=> (s_stb || !i_stb)); // R5
    AST_REARM: assert property (@(posedge clk) disable iff (rst)
      (s_ack || !i_cyc) |=> (s_stb == i_stb)); // R6

  end else begin : g_classic_classic
    assign s_stb   = i_stb;
    assign i_stall = 1'b0;
  end

endmodule

// File: tb/test_wb_mode_bridge.sv
`timescale 1ns/1ps
module test_wb_mode_bridge;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic          i_cyc, i_stb, i_we, s_ack, s_stall;
  logic [AW-1:0] i_adr;
  logic [SW-1:0] i_sel;
  logic [DW-1:0] i_dat_w, s_dat_r;

  logic [3:0][DW-1:0] o_dat_r, o_dat_w;
  logic [3:0][AW-1:0] o_adr;
  logic [3:0][SW-1:0] o_sel;
  logic [3:0]         o_ack, o_stall, o_cyc, o_stb, o_we;

  for (genvar k = 0; k < 4; k++) begin : g_cfg
    wb_mode_bridge #(.AW(AW), .DW(DW), .SW(SW),
                     .INI_PIPE(k[1]), .SUB_PIPE(k[0])) i_wb_mode_bridge (
      .clk(clk), .rst(rst),
      .i_cyc(i_cyc), .i_stb(i_stb), .i_adr(i_adr), .i_we(i_we),
      .i_sel(i_sel), .i_dat_w(i_dat_w),
      .i_dat_r(o_dat_r[k]), .i_ack(o_ack[k]), .i_stall(o_stall[k]),
      .s_cyc(o_cyc[k]), .s_stb(o_stb[k]), .s_adr(o_adr[k]), .s_we(o_we[k]),
      .s_sel(o_sel[k]), .s_dat_w(o_dat_w[k]),
      .s_dat_r(s_dat_r), .s_ack(s_ack), .s_stall(s_stall));
  end

  int total = 0;
  int bad   = 0;
  logic acc_m;   // bench model of the accepted flag (classic initiator, pipelined subordinate)

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_stall(input int k);
    if (k == 3) return s_stall;
    if (k == 2) return i_cyc & i_stb & ~s_ack;
    return 1'b0;
  endfunction

  function automatic logic exp_stb(input int k);
    if (k == 1) return i_stb & ~acc_m;
    return i_stb;
  endfunction

  task automatic check_all();
    for (int k = 0; k < 4; k++) begin
      logic [63:0] a, e;
      a = {o_cyc[k], o_we[k], o_adr[k], o_sel[k], o_dat_w[k] ^ o_dat_r[k]};
      e = {i_cyc, i_we, i_adr, i_sel, i_dat_w ^ s_dat_r};
      chk(a == e && o_dat_r[k] == s_dat_r, "R1", a, e);
      chk(o_ack[k] == s_ack, "R2", 64'(o_ack[k]), 64'(s_ack));
      chk(o_stall[k] == exp_stall(k), k == 3 ? "R3" : (k == 2 ? "R4" : "R7"),
          64'(o_stall[k]), 64'(exp_stall(k)));
      chk(o_stb[k] == exp_stb(k), k == 3 ? "R3" : (k == 2 ? "R4" : (k == 1 ? "R5 R6" : "R7")),
          64'(o_stb[k]), 64'(exp_stb(k)));
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) acc_m = 1'b0;
    else if (!i_cyc || s_ack) acc_m = 1'b0;
    else if (i_stb && !s_stall) acc_m = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(input logic cyc, input logic stb, input logic ack, input logic stall);
    i_cyc = cyc; i_stb = stb; s_ack = ack; s_stall = stall;
    i_adr = AW'($urandom); i_sel = SW'($urandom); i_we = 1'($urandom);
    i_dat_w = $urandom; s_dat_r = $urandom;
    #1;
    check_all();
    step();
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst = 1'b1; acc_m = 1'b0;
    i_cyc = 0; i_stb = 0; s_ack = 0; s_stall = 0; i_we = 0;
    i_adr = '0; i_sel = '0; i_dat_w = '0; s_dat_r = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(o_stb == 4'b0 && o_stall == 4'b0 && o_ack == 4'b0, "R8", 64'({o_stb, o_stall}), 64'(0));
    @(negedge clk);
    rst = 1'b0;

    // multi-cycle stall, acceptance, late ack, back-to-back request
    drive(1, 1, 0, 1); drive(1, 1, 0, 1); drive(1, 1, 0, 1);
    drive(1, 1, 0, 0);
    drive(1, 1, 0, 0); drive(1, 1, 0, 1);
    drive(1, 1, 1, 0);
    drive(1, 1, 0, 0);
    drive(1, 1, 1, 0);
    drive(1, 0, 0, 0);
    // abort with cyc low while accepted
    drive(1, 1, 0, 0); drive(1, 1, 0, 0);
    drive(0, 0, 0, 0);
    drive(1, 1, 0, 0);
    // reset while accepted
    drive(1, 1, 0, 0);
    i_cyc = 1; i_stb = 1; s_ack = 0; s_stall = 0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    #1;
    chk(o_stb[1] == 1'b1, "R8", 64'(o_stb[1]), 64'(1));
    step();

    for (int n = 0; n < 3000; n++) begin
      logic c, s, a, st;
      c  = ($urandom % 8) != 0;
      s  = ($urandom % 4) != 0;
      a  = ($urandom % 10) < 3;
      st = ($urandom % 10) < 4;
      drive(c, s, a, st);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule